// File: doc/BRIEF.md
# Frame-rate colour depth modulator

This block lets a colour passive-matrix panel that accepts only one bit per primary (eight native colours) show 4096 colours. Each incoming pixel carries a 4-bit level for red, green and blue. Over a repeating cycle of 16 frames, each channel is switched on in as many frames as its level says. The on-frames are not grouped together. They are scattered through the cycle by a fixed scrambling permutation. Each channel also starts that permutation at a different point, chosen from the pixel's position. This keeps neighbouring pixels and the three channels from toggling in step, and so hides the flicker.

The block sits between the pixel source and the panel drive. The timing generator pulses `frame_go` once per frame and presents pixels with `pix_vld`. The block returns the three drive bits one clock later. The panel should refresh at more than 320 frames per second, so that the 16-frame cycle repeats at 20 Hz or faster. The source may restrict itself to a subset of the colours, but every 4-bit level is handled.

Top module: `frc_dither`

## Requirements
- R1: While reset is low, `drv_rgb` and `drv_vld` are 0. After reset the frame phase is 0, so the first pixel is computed with phase 0.
- R2: The 4-bit frame phase advances by one on each clock where `frame_go` is 1 and wraps from 15 to 0. A pixel presented in the same clock as `frame_go` uses the phase from before the advance.
- R3: `drv_vld` equals `pix_vld` delayed by exactly one clock.
- R4: When `drv_vld` is 0, `drv_rgb` is 000 whatever the pixel inputs carry.
- R5: Let m = (p*11 + 5) mod 16, let r be m with its 4 bits reversed, and let perm(p) = r XOR 6. A channel with level L and phase p drives 1 exactly when perm(p) < L. The result appears one clock after the pixel.
- R6: Channel phase = (frame phase + col + 3*row + K) mod 16. Here col and row are the 4-bit position inputs, K is 10 for red, 5 for green and 0 for blue, and the sum is taken mod 16. The pixel packing is red in `pix_rgb[11:8]`, green in [7:4] and blue in [3:0]. The output bit order is red in `drv_rgb[2]`, green in [1] and blue in [0].
- R7: A channel at level 0 never drives 1.
- R8: With `lvl15_full` at 0, a channel at level L held at a fixed position is on in exactly L of any 16 consecutive frames.
- R9: With `lvl15_full` at 1, a channel at level 15 always drives 1. Levels 0 to 14 behave as in R5.
- R10: With `lvl15_full` at 0, a channel at level 15 is off in exactly one frame of every 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_go | input | 1 | One-clock pulse at each frame start |
| pix_vld | input | 1 | Pixel input is valid this clock |
| pix_rgb | input | 12 | Levels: red [11:8], green [7:4], blue [3:0] |
| pix_col | input | 4 | Pixel column, modulo 16 |
| pix_row | input | 4 | Pixel row, modulo 16 |
| lvl15_full | input | 1 | 1: level 15 is always on |
| drv_rgb | output | 3 | Panel drive bits: red [2], green [1], blue [0] |
| drv_vld | output | 1 | Drive bits valid |

## Verification
The sweep holds every level on every column for 16 frames, at two different rows, and counts the on-frames of each channel. A wrong permutation that is not a bijection, or a compare off by one, gives counts of L-1 or L+1. Level 0 that lights once, or level 15 that never turns off, shows up the same way. A swapped channel key or a wrong position weight does not change the counts. The per-clock model catches it instead, as a wrong bit on particular frames. Pixels that arrive together with a frame strobe, a second reset taken in the middle of a cycle, and idle cycles with a non-zero pixel on the bus each check an ordering a faulty design would get wrong: it would use the advanced phase, keep the old phase, or leak drive bits.

// File: rtl/frc_pkg.sv
package frc_pkg;
  localparam int LVL_W   = 4;
  localparam int NCH     = 3;
  localparam int PIX_W   = NCH * LVL_W;
  localparam int CH_STEP = 5;
  localparam int ROW_MUL = 3;

  typedef logic [LVL_W-1:0] lvl_t;

  // Bijective scramble of the 16 frame phases: affine map, bit reversal, xor.
  function automatic lvl_t scramble(lvl_t p);
    lvl_t m;
    lvl_t r;
    m = p * lvl_t'(11) + lvl_t'(5);
    for (int i = 0; i < LVL_W; i++) begin
      r[i] = m[LVL_W-1-i];
    end
    return r ^ lvl_t'(6);
  endfunction

  // Per-channel phase key: channel index times the step (blue 0, green 5, red 10).
  function automatic lvl_t chan_key(int c);
    return lvl_t'(c * CH_STEP);
  endfunction
endpackage

// File: rtl/frc_frame_ctr.sv
module frc_frame_ctr
  import frc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  output lvl_t phase
);
  lvl_t phase_d;

  always_comb begin
    phase_d = phase;
    if (adv) begin
      phase_d = phase + lvl_t'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
    end else begin
      phase <= phase_d;
    end
  end
endmodule

// File: rtl/frc_pos_offset.sv
module frc_pos_offset
  import frc_pkg::*;
(
  input  lvl_t                      col,
  input  lvl_t                      row,
  output logic [NCH-1:0][LVL_W-1:0] off
);
  lvl_t base;

  always_comb begin
    base = col + row * lvl_t'(ROW_MUL);
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    assign off[c] = base + chan_key(c);
  end
endmodule

// File: rtl/frc_level_gate.sv
module frc_level_gate
  import frc_pkg::*;
(
  input  lvl_t phase,
  input  lvl_t level,
  input  logic top_full,
  output logic on
);
  localparam lvl_t LVL_MAX = {LVL_W{1'b1}};
  lvl_t thresh;

  always_comb begin
    thresh = scramble(phase);
    on     = (thresh < level) || (top_full && (level == LVL_MAX));
  end
endmodule

// File: rtl/frc_dither.sv
module frc_dither
  import frc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_go,
  input  logic             pix_vld,
  input  logic [PIX_W-1:0] pix_rgb,
  input  logic [LVL_W-1:0] pix_col,
  input  logic [LVL_W-1:0] pix_row,
  input  logic             lvl15_full,
  output logic [NCH-1:0]   drv_rgb,
  output logic             drv_vld
);
  logic                      rst_meta_n;
  logic                      rst_sync_n;
  lvl_t                      frame_ph;
  logic [NCH-1:0][LVL_W-1:0] ch_off;
  logic [NCH-1:0]            ch_on;
  logic [NCH-1:0]            rgb_d;
  logic                      vld_d;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  frc_frame_ctr u_frame (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .adv   (frame_go),
    .phase (frame_ph)
  );

  frc_pos_offset u_pos (
    .col (pix_col),
    .row (pix_row),
    .off (ch_off)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_gate
    lvl_t ch_phase;
    assign ch_phase = frame_ph + ch_off[c];
    frc_level_gate u_gate (
      .phase    (ch_phase),
      .level    (pix_rgb[c*LVL_W +: LVL_W]),
      .top_full (lvl15_full),
      .on       (ch_on[c])
    );
  end

  always_comb begin
    vld_d = pix_vld;
    rgb_d = pix_vld ? ch_on : '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      drv_rgb <= '0;
      drv_vld <= 1'b0;
    end else begin
      drv_rgb <= rgb_d;
      drv_vld <= vld_d;
    end
  end
endmodule

// File: rtl/frc_dither_chk.sv
module frc_dither_chk
  import frc_pkg::*;
(
  input logic             clk,
  input logic             rst_ok,
  input logic             frame_go,
  input logic             pix_vld,
  input logic [PIX_W-1:0] pix_rgb,
  input logic             lvl15_full,
  input logic [LVL_W-1:0] phase,
  input logic [NCH-1:0]   drv_rgb,
  input logic             drv_vld
);
  logic armed;

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      armed <= 1'b0;
    end else begin
      armed <= 1'b1;
    end
  end

  p_vld_delay_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    armed |-> (drv_vld == $past(pix_vld)));

  p_idle_zero_r4: assert property (@(posedge clk) disable iff (!rst_ok)
    !drv_vld |-> (drv_rgb == '0));

  p_frame_adv_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    (armed && $past(frame_go)) |-> (phase == LVL_W'($past(phase) + 1)));

  p_frame_hold_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    (armed && !$past(frame_go)) |-> (phase == $past(phase)));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    p_lvl0_off_r7: assert property (@(posedge clk) disable iff (!rst_ok)
      (armed && drv_vld && ($past(pix_rgb[c*LVL_W +: LVL_W]) == '0)) |-> !drv_rgb[c]);

    p_full_on_r9: assert property (@(posedge clk) disable iff (!rst_ok)
      (armed && drv_vld && $past(lvl15_full) && ($past(pix_rgb[c*LVL_W +: LVL_W]) == '1))
        |-> drv_rgb[c]);
  end
endmodule

bind frc_dither frc_dither_chk u_chk (
  .clk        (clk),
  .rst_ok     (rst_sync_n),
  .frame_go   (frame_go),
  .pix_vld    (pix_vld),
  .pix_rgb    (pix_rgb),
  .lvl15_full (lvl15_full),
  .phase      (frame_ph),
  .drv_rgb    (drv_rgb),
  .drv_vld    (drv_vld)
);

// File: tb/frc_dither_test.sv
module frc_dither_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_go = 1'b0;
  logic        pix_vld = 1'b0;
  logic [11:0] pix_rgb = '0;
  logic [3:0]  pix_col = '0;
  logic [3:0]  pix_row = '0;
  logic        lvl15_full = 1'b0;
  logic [2:0]  drv_rgb;
  logic        drv_vld;

  int errs = 0;
  int checks = 0;
  int mf = 0;                 // model frame phase
  int cnt [3][16][16];        // [channel][column][level] on-frame counts

  always #5 clk = ~clk;

  frc_dither uut (
    .clk(clk), .rst_n(rst_n), .frame_go(frame_go), .pix_vld(pix_vld),
    .pix_rgb(pix_rgb), .pix_col(pix_col), .pix_row(pix_row),
    .lvl15_full(lvl15_full), .drv_rgb(drv_rgb), .drv_vld(drv_vld)
  );

  function automatic int bperm(int p);
    int m = (p * 11 + 5) % 16;
    int r = 0;
    for (int i = 0; i < 4; i++) if ((m >> i) & 1) r |= 1 << (3 - i);
    return r ^ 6;
  endfunction

  // R5 / R6 / R9 expected drive bits for a pixel at model phase mf
  function automatic logic [2:0] expect_rgb(int fph, logic [11:0] px, int cx, int ry, bit full);
    logic [2:0] e;
    for (int c = 0; c < 3; c++) begin
      int lvl = (px >> (4 * c)) & 15;
      int ph  = (fph + cx + 3 * ry + 5 * c) % 16;
      e[c] = (full && lvl == 15) || (bperm(ph) < lvl);
    end
    return e;
  endfunction

  task automatic step(input bit fs, input bit vld, input logic [11:0] px,
                      input int cx, input int ry, input bit full,
                      input string tag, output logic [2:0] got);
    logic [2:0] e_rgb;
    e_rgb = vld ? expect_rgb(mf, px, cx, ry, full) : 3'b000;
    frame_go = fs; pix_vld = vld; pix_rgb = px;
    pix_col = 4'(cx); pix_row = 4'(ry); lvl15_full = full;
    if (fs) mf = (mf + 1) % 16;
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (drv_rgb !== e_rgb || drv_vld !== vld) begin
      errs++;
      $display("FAIL %s: rgb=%b vld=%b expected rgb=%b vld=%b", tag, drv_rgb, drv_vld, e_rgb, vld);
    end
    got = drv_rgb;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    frame_go = 0; pix_vld = 0; pix_rgb = 12'hFFF;
    @(negedge clk);
    checks++;
    if (drv_rgb !== 3'b000 || drv_vld !== 1'b0) begin
      errs++;
      $display("FAIL R1: rgb=%b vld=%b expected rgb=000 vld=0", drv_rgb, drv_vld);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    mf = 0;
  endtask

  // R8 R7 R10 R9: 16 frames over every column and level, then count on-frames
  task automatic sweep(input int ry, input bit full);
    logic [2:0] g;
    for (int c = 0; c < 3; c++)
      for (int x = 0; x < 16; x++)
        for (int l = 0; l < 16; l++) cnt[c][x][l] = 0;
    for (int f = 0; f < 16; f++) begin
      step(1'b1, 1'b0, 12'h000, 0, ry, full, "R2 frame strobe", g);
      for (int x = 0; x < 16; x++) begin
        for (int l = 0; l < 16; l++) begin
          logic [11:0] px;
          px = {4'(l), 4'(15 - l), 4'((l + 7) % 16)};
          step(1'b0, 1'b1, px, x, ry, full, "R5 R6 pixel", g);
          cnt[2][x][l] += int'(g[2]);
          cnt[1][x][15 - l] += int'(g[1]);
          cnt[0][x][(l + 7) % 16] += int'(g[0]);
        end
        step(1'b0, 1'b0, 12'hFFF, x, ry, full, "R4 idle", g);
      end
    end
    for (int c = 0; c < 3; c++)
      for (int x = 0; x < 16; x++)
        for (int l = 0; l < 16; l++) begin
          int exp_n = (full && l == 15) ? 16 : l;
          checks++;
          if (cnt[c][x][l] != exp_n) begin
            errs++;
            $display("FAIL %s: ch=%0d col=%0d level=%0d on-frames=%0d expected %0d",
                     (l == 0) ? "R7" : (l == 15) ? (full ? "R9" : "R10") : "R8",
                     c, x, l, cnt[c][x][l], exp_n);
          end
        end
  endtask

  initial begin
    logic [2:0] g;
    do_reset();
    // R1: first pixel after reset uses phase 0
    step(1'b0, 1'b1, 12'h8A3, 0, 0, 1'b0, "R1 phase after reset", g);
    // R3: valid follows input one clock later, back to back and isolated
    step(1'b0, 1'b1, 12'h5F1, 3, 2, 1'b0, "R3 back to back", g);
    step(1'b0, 1'b0, 12'h5F1, 3, 2, 1'b0, "R3 R4 drop", g);
    // R2: pixel together with frame strobe uses old phase; wrap through 15
    for (int f = 0; f < 20; f++)
      step(1'b1, 1'b1, 12'h7C9, f % 16, 5, 1'b0, "R2 pixel with strobe", g);
    sweep(0, 1'b0);
    sweep(7, 1'b1);
    // R1: reset in mid-cycle clears the phase
    step(1'b1, 1'b0, 12'h000, 0, 0, 1'b0, "R2 strobe", g);
    step(1'b1, 1'b0, 12'h000, 0, 0, 1'b0, "R2 strobe", g);
    do_reset();
    for (int x = 0; x < 16; x++)
      step(1'b0, 1'b1, 12'h969, x, 0, 1'b0, "R1 phase after second reset", g);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule